// File: doc/BRIEF.md
# Serial EEPROM Port Arbiter and Ready Timer

This block is a single control register. Through it, firmware bit-bangs an external one-bit serial EEPROM that sits behind a memory port shared with another client. Firmware writes a request bit to ask for the port. The block waits until the other client no longer holds the port, then takes ownership. From that point three register bits drive the EEPROM chip-select, clock and serial data-in pins, and a fourth register bit returns the EEPROM's serial output.

A ready flag in the register has two roles. Its first rise reports that the port has been won, and that rise carries no timing meaning. After the grant, every register write clears ready, and ready comes back exactly a fixed delay later. The delay is set as a time and converted to clock cycles from the clock period, so firmware can pace the EEPROM clock edges. Clearing the request bit gives the port back at once and forces the pins low.

Two further register bits pass an arbitration handshake to logic outside the block: an outgoing request, and a read-only acknowledge.

Top module: `eeprom_port_ctl`

## Requirements
- R1: After reset the register reads 0x00 when the acknowledge input is low, and the port-own output and all three EEPROM output pins are low.
- R2: Writing a value with bit 5 (request) set while `port_busy` is low gives the port one clock after the write edge. In that same cycle `port_own` goes high and bit 4 (ready) reads 1.
- R3: While `port_busy` is high, a pending request is not granted and ready reads 0. The grant is taken on the first clock edge at which `port_busy` is sampled low.
- R4: While the port is owned, register bits 3, 2 and 1 drive `ee_cs`, `ee_sck` and `ee_di` respectively, and those bits read back as written.
- R5: While the port is owned, bit 0 reads `ee_do` after `DIN_SYNC_STAGES` clock edges (two by default). While the port is not owned, bit 0 reads 0.
- R6: A write that keeps bit 5 set while the port is owned makes ready read 0 from the write edge. Ready reads 1 again exactly READY_CYCLES edges after the write edge, where READY_CYCLES = ceil(READY_DELAY_PS / CLK_PERIOD_PS), which is 80 by default.
- R7: A further write during the ready delay restarts the full delay from the new write edge.
- R8: A write with bit 5 clear releases the port on that write edge: `port_own` and ready are 0 from the next sample on.
- R9: While the port is not owned, `ee_cs`, `ee_sck` and `ee_di` stay low whatever the register holds.
- R10: Bit 6 is writable and drives `ext_arb_req`. Bit 7 is read-only and reads `ext_arb_ack`.
- R11: Write data in bits 7, 4 and 0 has no effect. Those bits always read the acknowledge input, the ready state and the EEPROM data, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| port_busy | input | 1 | Other client currently holds the memory port |
| port_own | output | 1 | This block owns the memory port |
| ext_arb_req | output | 1 | External arbitration request (bit 6) |
| ext_arb_ack | input | 1 | External arbitration acknowledge (read as bit 7) |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sck | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data out of the EEPROM |

## Verification
Register fields and pins change on the write edge itself, so they are sampled at the falling edge right after the write. The grant and the first ready rise come one edge later. The EEPROM data bit comes two edges after `ee_do` changes. The timer's ready is checked both one cycle before and at exactly READY_CYCLES edges after the write, so an early or late rise is caught, and the restart case is checked past the point where the first window would have ended. Random pin patterns are written over a held grant, and each readback and pin state is compared with the bench's own model.

// File: rtl/epc_pkg.sv
package epc_pkg;
   localparam int REG_W  = 8;
   // register bit positions
   localparam int B_DIN  = 0;
   localparam int B_DOUT = 1;
   localparam int B_CLK  = 2;
   localparam int B_CS   = 3;
   localparam int B_RDY  = 4;
   localparam int B_REQ  = 5;
   localparam int B_XREQ = 6;
   localparam int B_XACK = 7;

   typedef struct packed {
      logic xreq;
      logic req;
      logic cs;
      logic ck;
      logic dout;
   } ctl_t;
endpackage

// File: rtl/epc_ctl_reg.sv
module epc_ctl_reg
   import epc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output ctl_t             ctl,
   output logic             req_drop
);
   ctl_t ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_en) begin
         ctl_q.xreq <= wr_data[B_XREQ];
         ctl_q.req  <= wr_data[B_REQ];
         ctl_q.cs   <= wr_data[B_CS];
         ctl_q.ck   <= wr_data[B_CLK];
         ctl_q.dout <= wr_data[B_DOUT];
      end
   end

   assign ctl      = ctl_q;
   assign req_drop = wr_en & ~wr_data[B_REQ];

   AST_REQ_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ctl.req == $past(wr_data[B_REQ]))); // R8
endmodule

// File: rtl/epc_arbiter.sv
module epc_arbiter (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic req_drop,
   input  logic busy,
   output logic grant_set,
   output logic granted
);
   logic own_q;

   assign grant_set = req & ~own_q & ~busy & ~req_drop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             own_q <= 1'b0;
      else if (req_drop)      own_q <= 1'b0;
      else if (!req)          own_q <= 1'b0;
      else if (grant_set)     own_q <= 1'b1;
   end

   assign granted = own_q;

   AST_GRANT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(granted) |-> $past(!busy)); // R3
   AST_PENDING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (req && busy && !granted) |=> !granted); // R3
   AST_RELEASE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      req_drop |=> !granted); // R8
endmodule

// File: rtl/epc_ready_timer.sv
module epc_ready_timer #(
   parameter int READY_CYCLES = 80,
   localparam int CNT_W = (READY_CYCLES < 2) ? 1 : $clog2(READY_CYCLES)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic granted,
   input  logic grant_set,
   input  logic release_now,
   input  logic wr_hit,
   output logic ready
);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(READY_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             rdy_q;

   initial begin
      if (READY_CYCLES < 1) $error("READY_CYCLES must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q <= 1'b0;
         cnt_q <= '0;
      end else if (release_now) begin
         rdy_q <= 1'b0;
         cnt_q <= '0;
      end else if (grant_set) begin
         rdy_q <= 1'b1;          // grant report, untimed
         cnt_q <= '0;
      end else if (wr_hit) begin
         rdy_q <= 1'b0;
         cnt_q <= LOAD;
      end else if (granted && !rdy_q) begin
         if (cnt_q == '0) rdy_q <= 1'b1;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign ready = rdy_q;

   AST_READY_NEEDS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> granted); // R8
   AST_WRITE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !release_now) |=> !ready); // R6
endmodule

// File: rtl/epc_pin_mux.sv
module epc_pin_mux #(
   parameter int DIN_SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic own,
   input  logic cs_bit,
   input  logic ck_bit,
   input  logic dout_bit,
   input  logic ee_do,
   output logic ee_cs,
   output logic ee_sck,
   output logic ee_di,
   output logic din_bit
);
   logic din_s;

   initial begin
      if (DIN_SYNC_STAGES < 0 || DIN_SYNC_STAGES > 4)
         $error("DIN_SYNC_STAGES must be 0..4");
   end

   generate
      if (DIN_SYNC_STAGES == 0) begin : g_direct
         assign din_s = ee_do;
      end else begin : g_sync
         logic [DIN_SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[DIN_SYNC_STAGES-2:0], ee_do};
         end
         assign din_s = sh_q[DIN_SYNC_STAGES-1];
      end
   endgenerate

   assign ee_cs   = own & cs_bit;
   assign ee_sck  = own & ck_bit;
   assign ee_di   = own & dout_bit;
   assign din_bit = own & din_s;

   AST_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !own |-> !(ee_cs || ee_sck || ee_di)); // R9
endmodule

// File: rtl/eeprom_port_ctl.sv
module eeprom_port_ctl
   import epc_pkg::*;
#(
   parameter int CLK_PERIOD_PS   = 10000,
   parameter int READY_DELAY_PS  = 800000,
   parameter int DIN_SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             port_busy,
   output logic             port_own,
   output logic             ext_arb_req,
   input  logic             ext_arb_ack,
   output logic             ee_cs,
   output logic             ee_sck,
   output logic             ee_di,
   input  logic             ee_do
);
   localparam int READY_CYCLES = (READY_DELAY_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

   initial begin
      if (CLK_PERIOD_PS <= 0)  $error("CLK_PERIOD_PS must be positive");
      if (READY_DELAY_PS <= 0) $error("READY_DELAY_PS must be positive");
   end

   ctl_t ctl;
   logic req_drop, grant_set, granted, ready, din_bit, wr_hit;

   epc_ctl_reg u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .ctl(ctl), .req_drop(req_drop)
   );

   epc_arbiter u_arb (
      .clk(clk), .rst_n(rst_n), .req(ctl.req), .req_drop(req_drop),
      .busy(port_busy), .grant_set(grant_set), .granted(granted)
   );

   assign wr_hit = wr_en & granted & wr_data[B_REQ];

   epc_ready_timer #(.READY_CYCLES(READY_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .granted(granted), .grant_set(grant_set),
      .release_now(req_drop), .wr_hit(wr_hit), .ready(ready)
   );

   epc_pin_mux #(.DIN_SYNC_STAGES(DIN_SYNC_STAGES)) u_pin (
      .clk(clk), .rst_n(rst_n), .own(granted), .cs_bit(ctl.cs),
      .ck_bit(ctl.ck), .dout_bit(ctl.dout), .ee_do(ee_do),
      .ee_cs(ee_cs), .ee_sck(ee_sck), .ee_di(ee_di), .din_bit(din_bit)
   );

   always_comb begin
      rd_data          = '0;
      rd_data[B_XACK]  = ext_arb_ack;
      rd_data[B_XREQ]  = ctl.xreq;
      rd_data[B_REQ]   = ctl.req;
      rd_data[B_RDY]   = ready;
      rd_data[B_CS]    = ctl.cs;
      rd_data[B_CLK]   = ctl.ck;
      rd_data[B_DOUT]  = ctl.dout;
      rd_data[B_DIN]   = din_bit;
   end

   assign port_own    = granted;
   assign ext_arb_req = ctl.xreq;

   AST_XREQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ext_arb_req == $past(wr_data[B_XREQ]))); // R10
endmodule

// File: tb/sim_eeprom_port_ctl.sv
module sim_eeprom_port_ctl;
   localparam int CLK_NS   = 10;
   localparam int RDY_CYC  = 800 / CLK_NS;   // 800 ns at 10 ns
   localparam int SYNC     = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       port_busy = 1'b0;
   logic       port_own;
   logic       ext_arb_req;
   logic       ext_arb_ack = 1'b0;
   logic       ee_cs, ee_sck, ee_di;
   logic       ee_do = 1'b0;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_NS/2) clk = ~clk;

   eeprom_port_ctl u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .port_busy(port_busy), .port_own(port_own),
      .ext_arb_req(ext_arb_req), .ext_arb_ack(ext_arb_ack),
      .ee_cs(ee_cs), .ee_sck(ee_sck), .ee_di(ee_di), .ee_do(ee_do)
   );

   task automatic check(input string rq, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h", rq, act, exp);
      end
   endtask

   // expected pins {cs,sck,di} from ownership and written value
   function automatic logic [7:0] exp_pins(input logic own, input logic [7:0] v);
      return own ? {5'b0, v[3], v[2], v[1]} : 8'h00;
   endfunction

   // expected readback
   function automatic logic [7:0] exp_rd(input logic [7:0] v, input logic rdy,
                                         input logic din, input logic ack);
      return {ack, v[6], v[5], rdy, v[3], v[2], v[1], din};
   endfunction

   function automatic logic [7:0] pins();
      return {5'b0, ee_cs, ee_sck, ee_di};
   endfunction

   task automatic wr(input logic [7:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_NS * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
   end

   initial begin
      logic [7:0] v;
      void'($urandom(1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 rd", rd_data, 8'h00);
      check("R1 pins", pins(), 8'h00);
      check("R1 own", {7'b0, port_own}, 8'h00);

      // R3 request pending while busy; R9 pins idle
      port_busy = 1'b1;
      wr(8'h2C);
      check("R9 pins while pending", pins(), 8'h00);
      repeat (5) @(negedge clk);
      check("R3 pending rd", rd_data, exp_rd(8'h2C, 1'b0, 1'b0, 1'b0));
      check("R3 pending own", {7'b0, port_own}, 8'h00);
      port_busy = 1'b0;
      @(negedge clk);
      check("R3 grant after idle", {7'b0, port_own}, 8'h01);
      check("R3 ready on grant", rd_data, exp_rd(8'h2C, 1'b1, 1'b0, 1'b0));
      check("R4 pins", pins(), exp_pins(1'b1, 8'h2C));

      // R8 release clears immediately, R9 pins low with bits held
      wr(8'h0E);
      check("R8 own", {7'b0, port_own}, 8'h00);
      check("R8 rd", rd_data, exp_rd(8'h0E, 1'b0, 1'b0, 1'b0));
      check("R9 pins after release", pins(), 8'h00);

      // R2 direct grant, one cycle after write
      wr(8'h20);
      check("R2 not yet", {7'b0, port_own}, 8'h00);
      @(negedge clk);
      check("R2 own", {7'b0, port_own}, 8'h01);
      check("R2 ready", rd_data, exp_rd(8'h20, 1'b1, 1'b0, 1'b0));

      // R6 timer
      wr(8'h22);
      check("R6 ready dropped", {7'b0, rd_data[4]}, 8'h00);
      check("R4 di pin", pins(), exp_pins(1'b1, 8'h22));
      repeat (RDY_CYC - 1) @(negedge clk);
      check("R6 one before", {7'b0, rd_data[4]}, 8'h00);
      @(negedge clk);
      check("R6 ready back", {7'b0, rd_data[4]}, 8'h01);

      // R7 restart
      wr(8'h24);
      repeat (40) @(negedge clk);
      wr(8'h28);
      repeat (RDY_CYC - 1) @(negedge clk);
      check("R7 restarted", {7'b0, rd_data[4]}, 8'h00);
      @(negedge clk);
      check("R7 ready", {7'b0, rd_data[4]}, 8'h01);

      // R5 data in
      ee_do = 1'b1;
      @(negedge clk);
      check("R5 not yet", {7'b0, rd_data[0]}, 8'h00);
      repeat (SYNC - 1) @(negedge clk);
      check("R5 din high", {7'b0, rd_data[0]}, 8'h01);
      ee_do = 1'b0;
      repeat (SYNC) @(negedge clk);
      check("R5 din low", {7'b0, rd_data[0]}, 8'h00);

      // R11 read-only bits ignore writes
      wr(8'hB1);
      check("R11 rd", rd_data, exp_rd(8'h20, 1'b0, 1'b0, 1'b0));

      // random pin patterns over a held grant (R4)
      for (int i = 0; i < 40; i++) begin
         v = (8'($urandom) & 8'h0E) | 8'h20;
         wr(v);
         check("R4 rand pins", pins(), exp_pins(1'b1, v));
         check("R4 rand rd", rd_data, exp_rd(v, 1'b0, 1'b0, 1'b0));
         repeat (int'($urandom % 3)) @(negedge clk);
      end

      // R10 external handshake bits; request cleared -> release
      ext_arb_ack = 1'b1;
      wr(8'h40);
      check("R10 xreq", {7'b0, ext_arb_req}, 8'h01);
      check("R10 rd", rd_data, exp_rd(8'h40, 1'b0, 1'b0, 1'b1));
      ee_do = 1'b1;
      repeat (SYNC + 1) @(negedge clk);
      check("R5 din masked", {7'b0, rd_data[0]}, 8'h00);
      wr(8'h00);
      check("R10 xreq clear", {7'b0, ext_arb_req}, 8'h00);

      summary();
   end
endmodule